// File: doc/BRIEF.md
# Set-Associative Cache Tag and Data Store

This block is the storage and lookup part of a small cache. It holds eight 16-byte lines (128 bytes) for a 10-bit byte address, organised as 1, 2 or 4 ways per set by a parameter. The total capacity stays the same in every organisation, so the split between index and tag moves with the associativity. Every access reads all ways of the addressed set at once and compares their tags in parallel. It reports a hit, the way that hit and the requested 32-bit word, all in the same cycle.

When an access misses, the line is filled from a refill bus that carries a whole line in one beat. The line is written into a victim way at the clock edge that ends the access. The victim is the lowest-numbered empty way if there is one. Otherwise it is the lowest-numbered way whose recently-used flag is clear. If every flag in the set is set, a free-running 2-bit counter picks the way. Recently-used flags are set by hits and by fills, and all of them are wiped at a fixed interval. This gives an approximation of least-recently-used replacement at the cost of one bit per line.

Top module: `sa_cache_store`

## Requirements
- R1: Address bits [1:0] select the byte and bits [3:2] select the word in the line. The set index is 3, 2 or 1 bits (bits [6:4], [5:4] or [4]) for 1, 2 or 4 ways. The remaining upper bits form the tag, which is 3, 4 or 5 bits wide.
- R2: With `acc_valid` high, `hit` is 1 in the same cycle exactly when some valid way of the indexed set holds the address tag, and `hit_way` gives that way.
- R3: `rd_word` is the word chosen by address bits [3:2]. On a hit it comes from the hitting line. On a miss it comes from `fill_data`, where word k occupies bits [32k+31:32k].
- R4: A miss with `acc_valid` high writes `fill_data` and the tag into the way shown on `victim_way` in that cycle. From the next cycle, an access to that line hits in that way.
- R5: While the indexed set has an empty way, `victim_way` is the lowest-numbered empty way.
- R6: While all ways of the set are valid and at least one has its recently-used flag clear, `victim_way` is the lowest-numbered way with a clear flag.
- R7: While all ways are valid and all flags are set, `victim_way` is a free-running 2-bit counter modulo the number of ways. It advances by one each cycle.
- R8: An access sets the recently-used flag of the way that hit, or of the way that was filled.
- R9: Every `CLR_INTERVAL` cycles, all recently-used flags are cleared. An access in the same cycle still sets its own flag.
- R10: Reset is asserted asynchronously and released after two rising edges. Reset leaves every way empty, so no access hits and the victim is way 0.
- R11: From an empty cache, the addresses 0100111000, 1100110100, 0100111100, 0110110000, 1100111000 give these results. 1 way: miss, miss, miss, miss, miss. 2 ways: miss, miss, hit, miss (the fifth result depends on the counter). 4 ways: miss, miss, hit, miss, hit.
- R12: With `acc_valid` low, `hit` is 0 and no line or flag changes. `victim_way` still reflects the set of `acc_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe; the access commits at the next rising edge |
| acc_addr | input | ADDR_W | Byte address of the access |
| fill_data | input | WORD_W*BLK_WORDS | Refill line, used only when the access misses |
| hit | output | 1 | Access hit in the indexed set |
| hit_way | output | WAY_W | Way that hit |
| rd_word | output | WORD_W | Requested word from the hit line or from the refill |
| victim_way | output | WAY_W | Way a miss to this set would fill |

## Verification
`hit`, `hit_way`, `rd_word` and `victim_way` are combinational in the cycle an address is presented. Fills and flag updates take effect at the rising edge that closes the access, so their effects appear one cycle later. The flag clear lands on the edge after the interval counter wraps. The bench drives inputs on the falling edge and samples outputs 5 ns later, before the committing edge. It checks the consequences of an access only in a later cycle. Because the phase of the interval clear is not visible at the ports, the bench waits until the victim holds at way 0 for two cycles in a full set. It then does all use-bit checks within a few cycles, well inside one interval.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
  // width of the free-running fallback selector
  localparam int unsigned RND_W = 2;

  // ceil(log2(n)), never below 1 so that single-entry fields stay legal
  function automatic int unsigned clog2_min1(input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 31; i++) begin
      if ((32'd1 << i) < n) r = i + 1;
    end
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/cache_rst_sync.sv
`timescale 1ns/1ps
module cache_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cache_way_store.sv
`timescale 1ns/1ps
module cache_way_store #(
  parameter int unsigned SETS  = 2,
  parameter int unsigned IDX_W = 1,
  parameter int unsigned TAG_W = 5,
  parameter int unsigned BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_line,
  output logic             line_valid,
  output logic             tag_match,
  output logic [BLK_W-1:0] line_data
);
  logic [SETS-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [BLK_W-1:0] data_q [SETS];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q <= valid_d;
  end

  // tag and data arrays carry no reset; the valid bit guards them
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[set_idx]  <= cmp_tag;
      data_q[set_idx] <= wr_line;
    end
  end

  assign line_valid = valid_q[set_idx];
  assign tag_match  = line_valid && (tag_q[set_idx] == cmp_tag);
  assign line_data  = data_q[set_idx];
endmodule

// File: rtl/cache_victim_sel.sv
`timescale 1ns/1ps
module cache_victim_sel #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned RND_W = 2
) (
  input  logic [WAYS-1:0]  line_valid,
  input  logic [WAYS-1:0]  line_used,
  input  logic [RND_W-1:0] rnd,
  output logic [WAY_W-1:0] victim
);
  always_comb begin
    // lowest priority: counter fallback
    victim = WAY_W'(rnd & RND_W'(WAYS - 1));
    // middle: lowest way not recently used
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!line_used[w]) victim = WAY_W'(w);
    end
    // highest: lowest empty way
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!line_valid[w]) victim = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cache_use_ctl.sv
`timescale 1ns/1ps
module cache_use_ctl
  import cache_pkg::*;
#(
  parameter int unsigned SETS         = 2,
  parameter int unsigned WAYS         = 4,
  parameter int unsigned IDX_W        = 1,
  parameter int unsigned WAY_W        = 2,
  parameter int unsigned CLR_INTERVAL = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic                 mark_en,
  input  logic [WAY_W-1:0]     mark_way,
  output logic [WAYS-1:0]      set_used,
  output logic [RND_W-1:0]     rnd,
  output logic                 clr_pulse,
  output logic [SETS*WAYS-1:0] use_all
);
  localparam int unsigned LINES = SETS * WAYS;
  localparam int unsigned POS_W = clog2_min1(LINES);
  localparam int unsigned CNT_W = clog2_min1(CLR_INTERVAL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic [LINES-1:0] use_q, use_d;
  logic             use_en;
  logic [POS_W-1:0] base_pos;

  assign base_pos  = POS_W'(set_idx) * POS_W'(WAYS);
  assign clr_pulse = (cnt_q == CNT_W'(CLR_INTERVAL - 1));
  assign use_en    = clr_pulse | mark_en;

  always_comb begin
    cnt_d = clr_pulse ? '0 : cnt_q + 1'b1;
    rnd_d = rnd_q + 1'b1;
    use_d = clr_pulse ? '0 : use_q;
    if (mark_en) use_d[base_pos + POS_W'(mark_way)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rnd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rnd_q <= rnd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      use_q <= '0;
    else if (use_en) use_q <= use_d;
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_used[w] = use_q[base_pos + POS_W'(w)];
    end
  end

  assign rnd     = rnd_q;
  assign use_all = use_q;
endmodule

// File: rtl/sa_cache_store.sv
`timescale 1ns/1ps
module sa_cache_store
  import cache_pkg::*;
#(
  parameter int unsigned ADDR_W         = 10,
  parameter int unsigned WORD_W         = 32,
  parameter int unsigned BLK_WORDS      = 4,
  parameter int unsigned BYTES_PER_WORD = 4,
  parameter int unsigned NUM_BLOCKS     = 8,
  parameter int unsigned WAYS           = 4,
  parameter int unsigned CLR_INTERVAL   = 1024,
  localparam int unsigned WAY_W         = clog2_min1(WAYS),
  localparam int unsigned BLK_W         = WORD_W * BLK_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BLK_W-1:0]  fill_data,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [WORD_W-1:0] rd_word,
  output logic [WAY_W-1:0]  victim_way
);
  localparam int unsigned SETS   = NUM_BLOCKS / WAYS;
  localparam int unsigned BOFF_W = clog2_min1(BYTES_PER_WORD);
  localparam int unsigned WOFF_W = clog2_min1(BLK_WORDS);
  localparam int unsigned IDX_W  = clog2_min1(SETS);
  localparam int unsigned TAG_W  = ADDR_W - BOFF_W - WOFF_W - IDX_W;

  logic                 rst_sync_n;
  logic [WOFF_W-1:0]    woff;
  logic [IDX_W-1:0]     idx;
  logic [TAG_W-1:0]     tag;
  logic [WAYS-1:0]      way_valid, way_match, way_used, way_wr;
  logic [BLK_W-1:0]     way_data [WAYS];
  logic [WAY_W-1:0]     victim, match_way;
  logic [BLK_W-1:0]     sel_line;
  logic                 any_match, alloc_en;
  logic [RND_W-1:0]     rnd;
  logic                 clr_pulse;
  logic [SETS*WAYS-1:0] use_all;

  cache_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // address split: byte | word | index | tag
  assign woff = acc_addr[BOFF_W +: WOFF_W];
  assign idx  = acc_addr[BOFF_W + WOFF_W +: IDX_W];
  assign tag  = acc_addr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache_way_store #(
      .SETS  (SETS),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .BLK_W (BLK_W)
    ) u_way (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .set_idx    (idx),
      .cmp_tag    (tag),
      .wr_en      (way_wr[w]),
      .wr_line    (fill_data),
      .line_valid (way_valid[w]),
      .tag_match  (way_match[w]),
      .line_data  (way_data[w])
    );
  end

  always_comb begin
    any_match = |way_match;
    match_way = '0;
    sel_line  = fill_data;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_match[w]) begin
        match_way = WAY_W'(w);
        sel_line  = way_data[w];
      end
    end
  end

  cache_victim_sel #(
    .WAYS  (WAYS),
    .WAY_W (WAY_W),
    .RND_W (RND_W)
  ) u_victim (
    .line_valid (way_valid),
    .line_used  (way_used),
    .rnd        (rnd),
    .victim     (victim)
  );

  assign alloc_en = acc_valid && !any_match;

  always_comb begin
    way_wr = '0;
    if (alloc_en) way_wr = WAYS'(1) << victim;
  end

  cache_use_ctl #(
    .SETS         (SETS),
    .WAYS         (WAYS),
    .IDX_W        (IDX_W),
    .WAY_W        (WAY_W),
    .CLR_INTERVAL (CLR_INTERVAL)
  ) u_use (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_idx   (idx),
    .mark_en   (acc_valid),
    .mark_way  (any_match ? match_way : victim),
    .set_used  (way_used),
    .rnd       (rnd),
    .clr_pulse (clr_pulse),
    .use_all   (use_all)
  );

  assign hit        = acc_valid && any_match;
  assign hit_way    = match_way;
  assign rd_word    = sel_line[int'(woff) * WORD_W +: WORD_W];
  assign victim_way = victim;
endmodule

// File: rtl/cache_store_chk.sv
`timescale 1ns/1ps
module cache_store_chk
  import cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned WAY_W  = 2,
  parameter int unsigned SETS   = 2,
  parameter int unsigned IDX_W  = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic [ADDR_W-1:0]    acc_addr,
  input logic [IDX_W-1:0]     idx,
  input logic                 hit,
  input logic [WAY_W-1:0]     hit_way,
  input logic [WAY_W-1:0]     victim_way,
  input logic [WAYS-1:0]      way_valid,
  input logic [WAYS-1:0]      way_match,
  input logic [SETS*WAYS-1:0] use_all,
  input logic                 clr_pulse
);
  localparam int unsigned POS_W = clog2_min1(SETS * WAYS);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= POS_W'(idx) * POS_W'(WAYS) + POS_W'(hit ? hit_way : victim_way);
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match)); // R2

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hit) ##1 (acc_valid && acc_addr == $past(acc_addr))
      |-> (hit && hit_way == $past(victim_way))); // R4

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !(&way_valid) |-> !way_valid[victim_way]); // R5

  AST_USE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> use_all[pos_q]); // R8

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !acc_valid) |=> (use_all == '0)); // R9

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !hit); // R12
endmodule

bind sa_cache_store cache_store_chk #(
  .ADDR_W (ADDR_W),
  .WAYS   (WAYS),
  .WAY_W  (WAY_W),
  .SETS   (SETS),
  .IDX_W  (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .idx        (idx),
  .hit        (hit),
  .hit_way    (hit_way),
  .victim_way (victim_way),
  .way_valid  (way_valid),
  .way_match  (way_match),
  .use_all    (use_all),
  .clr_pulse  (clr_pulse)
);

// File: tb/test_sa_cache_store.sv
`timescale 1ns/1ps
module test_sa_cache_store;
  localparam int CLR = 64;

  logic         clk;
  logic         rst_n;
  logic         acc_valid;
  logic [9:0]   acc_addr;
  logic [127:0] fill_data;

  logic         hit4, hit2, hit1;
  logic [1:0]   way4;
  logic [0:0]   way2, way1;
  logic [31:0]  rd4, rd2, rd1;
  logic [1:0]   vic4;
  logic [0:0]   vic2, vic1;

  // sampled results, index c: 0 = 1 way, 1 = 2 ways, 2 = 4 ways
  int s_hit [3];
  int s_way [3];
  int s_rd  [3];
  int s_vic [3];

  int errors = 0;
  int checks = 0;
  bit done = 0;

  sa_cache_store #(.WAYS(4), .CLR_INTERVAL(CLR)) i_sa_cache_store (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .fill_data(fill_data), .hit(hit4), .hit_way(way4), .rd_word(rd4), .victim_way(vic4));
  sa_cache_store #(.WAYS(2), .CLR_INTERVAL(CLR)) i_sa_cache_store_w2 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .fill_data(fill_data), .hit(hit2), .hit_way(way2), .rd_word(rd2), .victim_way(vic2));
  sa_cache_store #(.WAYS(1), .CLR_INTERVAL(CLR)) i_sa_cache_store_w1 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .fill_data(fill_data), .hit(hit1), .hit_way(way1), .rd_word(rd1), .victim_way(vic1));

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] exp_word(input int blk, input int w);
    return 32'hC300_0000 | (32'(blk) << 8) | 32'(w);
  endfunction

  function automatic logic [127:0] line_of(input int blk);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = exp_word(blk, k);
    return l;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // present one cycle: drive at falling edge, sample 5 ns later
  task automatic cyc(input logic v, input logic [9:0] a, input logic use_fill);
    @(negedge clk);
    acc_valid = v;
    acc_addr  = a;
    fill_data = use_fill ? line_of(int'(a[9:4])) : '0;
    #5;
    s_hit[0] = int'(hit1); s_way[0] = int'(way1); s_rd[0] = int'(rd1); s_vic[0] = int'(vic1);
    s_hit[1] = int'(hit2); s_way[1] = int'(way2); s_rd[1] = int'(rd2); s_vic[1] = int'(vic2);
    s_hit[2] = int'(hit4); s_way[2] = int'(way4); s_rd[2] = int'(rd4); s_vic[2] = int'(vic4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    acc_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [9:0] seq [5];
    int         exp_hit [3][5];
    int         v1, v2, cap, prev, found;
    seq = '{10'b0100111000, 10'b1100110100, 10'b0100111100, 10'b0110110000, 10'b1100111000};
    exp_hit[0] = '{0, 0, 0, 0, 0};
    exp_hit[1] = '{0, 0, 1, 0, -1};
    exp_hit[2] = '{0, 0, 1, 0, 1};
    rst_n = 1'b0;
    acc_valid = 1'b0;
    acc_addr = '0;
    fill_data = '0;
    do_reset();

    // R10: empty after reset, victim is way 0, no hit while idle
    for (int b = 0; b < 8; b++) begin
      cyc(1'b0, 10'(b << 4), 1'b0);
      for (int c = 0; c < 3; c++) begin
        chk("R10 victim after reset", s_vic[c], 0);
        chk("R12 idle hit", s_hit[c], 0);
      end
    end

    // R11 / R3: reference sequence from cold start
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, seq[i], 1'b1);
      for (int c = 0; c < 3; c++) begin
        if (exp_hit[c][i] >= 0) chk("R11 sequence hit", s_hit[c], exp_hit[c][i]);
        chk("R3 word select", s_rd[c], int'(exp_word(int'(seq[i][9:4]), int'(seq[i][3:2]))));
      end
      if (i == 2) chk("R2 hit way 4-way", s_way[2], 0);
      if (i == 4) chk("R2 hit way 4-way", s_way[2], 1);
    end
    cyc(1'b0, '0, 1'b0);

    // R10: reset empties the store
    do_reset();
    cyc(1'b1, seq[2], 1'b1);
    for (int c = 0; c < 3; c++) chk("R10 miss after reset", s_hit[c], 0);

    // R1 R2 R3 R4 R5: fill all eight lines, then read every word
    do_reset();
    for (int b = 0; b < 8; b++) begin
      cyc(1'b0, 10'(b << 4), 1'b0);
      for (int c = 0; c < 3; c++) chk("R5 lowest empty way", s_vic[c], b >> (3 - c));
      cyc(1'b1, 10'(b << 4), 1'b1);
      for (int c = 0; c < 3; c++) chk("R4 fill miss", s_hit[c], 0);
    end
    for (int b = 0; b < 8; b++) begin
      for (int w = 0; w < 4; w++) begin
        cyc(1'b1, 10'((b << 4) | (w << 2) | w), 1'b0);
        for (int c = 0; c < 3; c++) begin
          chk("R1 R2 hit after fill", s_hit[c], 1);
          chk("R1 R4 hit way", s_way[c], b >> (3 - c));
          chk("R3 stored word", s_rd[c], int'(exp_word(b, w)));
        end
      end
    end

    // R12: strobe low must not allocate line 8 (set 0 in every organisation)
    cyc(1'b0, 10'h080, 1'b1);
    cyc(1'b0, 10'h080, 1'b1);
    for (int c = 0; c < 3; c++) chk("R12 idle hit", s_hit[c], 0);
    cyc(1'b1, 10'h000, 1'b0);
    for (int c = 0; c < 3; c++) chk("R12 line 0 kept", s_hit[c], 1);

    // R9: wait until the 4-way set 0 victim holds at 0 for two cycles
    found = 0;
    prev = 1;
    for (int t = 0; t < 4 * CLR && found == 0; t++) begin
      cyc(1'b0, 10'h000, 1'b0);
      if (s_vic[2] == 0 && prev == 0) found = 1;
      prev = s_vic[2];
    end
    chk("R9 periodic clear seen", found, 1);

    // R6 R8: 4-way set 0 holds lines 0,2,4,6 in ways 0..3
    cyc(1'b1, 10'h000, 1'b0);
    cyc(1'b1, 10'h020, 1'b0);
    cyc(1'b0, 10'h000, 1'b0);
    chk("R6 R8 lowest unused way", s_vic[2], 2);
    cyc(1'b1, 10'h040, 1'b0);
    cyc(1'b0, 10'h000, 1'b0);
    chk("R6 R8 lowest unused way", s_vic[2], 3);
    cyc(1'b1, 10'h060, 1'b0);

    // R7: all used, counter fallback steps by one per cycle
    cyc(1'b0, 10'h000, 1'b0);
    v1 = s_vic[2];
    cyc(1'b0, 10'h000, 1'b0);
    v2 = s_vic[2];
    chk("R7 counter step", v2, (v1 + 1) % 4);

    // R4 R7: miss fills the displayed victim, then hits there
    cyc(1'b1, 10'h080, 1'b1);
    cap = s_vic[2];
    chk("R4 new line misses", s_hit[2], 0);
    cyc(1'b1, 10'h080, 1'b0);
    chk("R4 filled line hits", s_hit[2], 1);
    chk("R4 R7 filled way", s_way[2], cap);
    chk("R3 filled word", s_rd[2], int'(exp_word(8, 0)));

    // R9: after two intervals idle, no flag survives
    repeat (2 * CLR + 4) cyc(1'b0, 10'h000, 1'b0);
    chk("R9 cleared 4-way", s_vic[2], 0);
    chk("R9 cleared 2-way", s_vic[1], 0);
    cyc(1'b0, 10'h000, 1'b0);
    chk("R9 stays cleared", s_vic[2], 0);

    finish_run();
  end
endmodule